// File: doc/BRIEF.md
# Byte-Packing SPI Master

This block is a serial-peripheral master whose data register can be accessed either one byte or two bytes at a time. Frames are always 8 bits wide. Every write to the data register places bytes into a transmit FIFO, and every read takes bytes out of a receive FIFO. The width of the access decides how many frames are moved. A two-byte write queues two frames, and the low byte goes out on the wire first. A two-byte read removes the two oldest received frames, with the earlier one in the low byte.

The receive-ready flag has a selectable threshold. It can wait for one buffered byte or for two. Software must keep the threshold in step with its read width, or frames can be left stranded. To end an odd-length packed sequence, software switches the threshold to one byte before the last frame arrives.

The serial side has the following properties:
- The clock idles low.
- Data is driven on the rising edge and sampled on the falling edge.
- The bit order is selectable.
- A baud field sets the clock divisor.
- Chip select is driven directly from a control bit.

Top module: `spi_pack_master`

## Requirements
- R1: A data write with `bus_wide`=1 queues `bus_wdata[7:0]` and then `bus_wdata[15:8]` as two frames, and the low byte is transmitted first. A data write with `bus_wide`=0 queues only `bus_wdata[7:0]`.
- R2: A data read with `bus_wide`=1 and at least two bytes buffered returns the older byte in bits 7:0 and the newer byte in bits 15:8, then removes both. A read with `bus_wide`=0 returns the oldest byte in bits 7:0 with zero in bits 15:8, then removes one.
- R3: A read with `bus_wide`=1 and exactly one byte buffered returns that byte in bits 7:0 with zero above it, and removes one entry. A data read of an empty FIFO returns 0.
- R4: With control bit 2 at 0, `rx_ready` is high only when at least two bytes are buffered. With control bit 2 at 1, `rx_ready` is high when at least one byte is buffered.
- R5: `tx_level` and `rx_level` encode the fill count as follows: 00 for empty, 01 for 1 to DEPTH/4 bytes, 10 for more than that but not full, and 11 for full.
- R6: Bytes of a write that do not fit in the transmit FIFO are dropped. A low byte that fits is still queued.
- R7: A byte that finishes receiving while the receive FIFO is full is discarded and sets `overrun`. `overrun` then stays high until reset.
- R8: Each frame gives 8 rising `sclk` edges. `mosi` changes only when `sclk` rises, and `miso` is sampled when `sclk` falls. Bits go MSB first when control bit 1 is 0, and LSB first when it is 1.
- R9: The `sclk` period is 2 << B system clocks, where B is the baud field in control bits [4:3]. B=1 gives divide-by-4.
- R10: `busy` is high while a frame is shifting. `sclk` is low whenever `busy` is low.
- R11: A frame starts only while control bit 0 (enable) is 1. Clearing the enable bit lets the current frame finish and leaves later bytes queued.
- R12: `cs_n` is the inverse of control bit 5. The control register is selected by `bus_addr`=0 and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Data read strobe (pops on the clock edge) |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wide | input | 1 | 1 = two-byte access, 0 = one-byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address and width |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| tx_level | output | 2 | Transmit FIFO level code |
| rx_level | output | 2 | Receive FIFO level code |
| rx_ready | output | 1 | Receive threshold reached |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with its defaults: DEPTH=4 and a 2-bit baud field. With a four-byte FIFO, two packed writes fill the transmit side, and five frames overflow the receive side. This brings the dropped-byte, partial-fit and overrun cases within a handful of frames. The 2-bit field covers divisors from 2 to 16, so the bench can measure the divide-by-4 and divide-by-16 periods. A loopback from `mosi` to `miso` turns every transmitted byte into a received one. This lets the packing order be checked at both the wire and the register.

// File: rtl/spi_pack_master.sv
module spi_pack_master #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic        bus_wide,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic [1:0]  tx_level,
  output logic [1:0]  rx_level,
  output logic        rx_ready,
  output logic        busy,
  output logic        overrun
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int CTW = 4 + DIV_W;
  localparam int HCW = (1 << DIV_W) - 1;

  logic [CTW-1:0] ctrl;
  wire en   = ctrl[0];
  wire lsb  = ctrl[1];
  wire thr8 = ctrl[2];
  wire [DIV_W-1:0] baud = ctrl[3 +: DIV_W];
  assign cs_n = ~ctrl[3 + DIV_W];

  function automatic logic [1:0] lvl(input logic [CW-1:0] c);
    if (c == '0) return 2'b00;
    if (c == CW'(DEPTH)) return 2'b11;
    if (c <= CW'(DEPTH / 4)) return 2'b01;
    return 2'b10;
  endfunction

  // transmit FIFO
  logic [7:0]    txm [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [CW-1:0] tcnt;
  wire dwr  = bus_wr && bus_addr;
  wire tok0 = dwr && (tcnt < CW'(DEPTH));
  wire tok1 = dwr && bus_wide && (tcnt + 1'b1 < CW'(DEPTH));

  // receive FIFO
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [CW-1:0] rcnt;
  wire drd  = bus_rd && bus_addr;
  wire rpop0 = drd && (rcnt != '0);
  wire rpop1 = drd && bus_wide && (rcnt >= CW'(2));

  // shift engine
  logic           sclk_q, mosi_q, busy_q;
  logic [7:0]     sh;
  logic [2:0]     nbit;
  logic [HCW-1:0] hc;
  wire [HCW-1:0] hlim = HCW'((32'd1 << baud) - 32'd1);
  wire start = en && !busy_q && (tcnt != '0);
  wire tick  = busy_q && (hc == hlim);
  wire done  = tick && sclk_q && (nbit == 3'd7);
  wire [7:0] sh_nx = lsb ? {miso, sh[7:1]} : {sh[6:0], miso};
  wire rpush = done && (rcnt < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (tok0) txm[twp] <= bus_wdata[7:0];
    if (tok1) txm[twp + 1'b1] <= bus_wdata[15:8];
    if (rpush) rxm[rwp] <= sh_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (bus_wr && !bus_addr) ctrl <= bus_wdata[CTW-1:0];
      twp  <= twp + AW'(tok0) + AW'(tok1);
      trp  <= trp + AW'(start);
      tcnt <= tcnt + CW'(tok0) + CW'(tok1) - CW'(start);
      rwp  <= rwp + AW'(rpush);
      rrp  <= rrp + AW'(rpop0) + AW'(rpop1);
      rcnt <= rcnt + CW'(rpush) - CW'(rpop0) - CW'(rpop1);
      if (done && !rpush) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      sh <= '0; nbit <= '0; hc <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sh     <= txm[trp];
      nbit   <= '0;
      hc     <= '0;
    end else if (busy_q) begin
      if (tick) begin
        hc     <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          mosi_q <= lsb ? sh[0] : sh[7];
        end else begin
          sh   <= sh_nx;
          nbit <= nbit + 1'b1;
          if (nbit == 3'd7) busy_q <= 1'b0;
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  wire [7:0] rlo = (rcnt != '0) ? rxm[rrp] : 8'h00;
  wire [7:0] rhi = (bus_wide && rcnt >= CW'(2)) ? rxm[rrp + 1'b1] : 8'h00;
  assign bus_rdata = bus_addr ? {rhi, rlo} : 16'(ctrl);

  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign busy     = busy_q;
  assign tx_level = lvl(tcnt);
  assign rx_level = lvl(rcnt);
  assign rx_ready = thr8 ? (rcnt != '0) : (rcnt >= CW'(2));
endmodule

// File: rtl/spi_pack_master_chk.sv
module spi_pack_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       mosi,
  input logic       busy,
  input logic       rx_ready,
  input logic [1:0] rx_level,
  input logic       overrun
);
  p_mosi_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sclk) |-> $stable(mosi));
  p_sclk_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  p_rise_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> busy);
  p_sticky_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> overrun);
  p_empty_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == 2'b00) |-> !rx_ready);
endmodule

bind spi_pack_master spi_pack_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .busy(busy),
  .rx_ready(rx_ready), .rx_level(rx_level), .overrun(overrun)
);

// File: tb/spi_pack_master_test.sv
`timescale 1ns/1ps
module spi_pack_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0, bus_wide = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sclk, mosi, cs_n, rx_ready, busy, overrun;
  logic [1:0] tx_level, rx_level;

  int checks = 0, errors = 0, cyc = 0;
  int last_rise = 0, prev_rise = 0;
  bit lsb_cfg = 0;
  logic [7:0] txq [$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_pack_master uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(mosi),
    .cs_n(cs_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_ready(rx_ready), .busy(busy), .overrun(overrun)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: decode wire bytes, compare against driver's queue (R1, R8)
  logic [7:0] wb = '0;
  int nb = 0;
  always @(negedge sclk) begin
    wb = lsb_cfg ? {mosi, wb[7:1]} : {wb[6:0], mosi};
    nb++;
    if (nb == 8) begin
      nb = 0;
      if (txq.size() == 0) check({8'h0, wb}, 16'hxxxx, "R1/R8 unexpected frame");
      else check({8'h0, wb}, {8'h0, txq.pop_front()}, "R1/R8 wire byte");
    end
  end
  always @(posedge sclk) begin
    prev_rise = last_rise;
    last_rise = cyc;
  end

  task automatic wr(input logic a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wide = w; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic send(input logic w, input logic [15:0] d, input int fit);
    if (fit >= 1) txq.push_back(d[7:0]);
    if (fit >= 2) txq.push_back(d[15:8]);
    wr(1'b1, w, d);
  endtask

  task automatic rd(input logic w, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = 1; bus_wide = w;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic quiet();
    do @(negedge clk); while (busy || tx_level != 2'b00);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    check({14'h0, sclk, cs_n}, 16'h0001, "R12 reset cs_n/sclk");
    check({10'h0, tx_level, rx_level, busy, overrun}, 16'h0, "R5 reset levels");
    check({15'h0, rx_ready}, 16'h0, "R4 reset rx_ready");
    rst_n = 1;

    // packed pair, 16-bit threshold
    wr(0, 0, 16'h0021);
    check({15'h0, cs_n}, 16'h0, "R12 cs asserted");
    send(1, 16'h5AB0, 2);
    check({14'h0, tx_level}, 16'h2, "R1 two frames queued");
    repeat (4) @(negedge clk);
    check({15'h0, busy}, 16'h1, "R10 busy in frame");
    quiet();
    check({14'h0, rx_level}, 16'h2, "R5 rx half");
    check({15'h0, rx_ready}, 16'h1, "R4 two bytes ready");
    check(16'(last_rise - prev_rise), 16'd2, "R9 divide by 2");
    rd(1, d); check(d, 16'h5AB0, "R2 wide read order");
    check({14'h0, rx_level}, 16'h0, "R2 both popped");

    // odd frame, threshold switch
    send(0, 16'hFF3C, 1);
    quiet();
    check({14'h0, rx_level}, 16'h1, "R5 rx quarter");
    check({15'h0, rx_ready}, 16'h0, "R4 one byte below 16-bit threshold");
    wr(0, 0, 16'h0025);
    check({15'h0, rx_ready}, 16'h1, "R4 8-bit threshold");
    rd(0, d); check(d, 16'h003C, "R2 narrow read");

    // LSB first, wide read of single byte
    lsb_cfg = 1;
    wr(0, 0, 16'h0027);
    send(0, 16'h0012, 1);
    quiet();
    rd(1, d); check(d, 16'h0012, "R3 wide read one byte");
    check({14'h0, rx_level}, 16'h0, "R3 one popped");
    rd(1, d); check(d, 16'h0000, "R3 empty read");
    lsb_cfg = 0;

    // drops on full transmit FIFO, enable off
    wr(0, 0, 16'h0024);
    send(1, 16'h2211, 2);
    send(0, 16'h0033, 1);
    check({14'h0, tx_level}, 16'h2, "R5 three is half");
    send(1, 16'h5544, 1);
    check({14'h0, tx_level}, 16'h3, "R6 partial fit full");
    send(0, 16'h0066, 0);
    check({14'h0, tx_level}, 16'h3, "R6 drop on full");
    repeat (20) @(negedge clk);
    check({15'h0, busy}, 16'h0, "R11 no start while disabled");
    wr(0, 0, 16'h0021);
    quiet();
    check({14'h0, rx_level}, 16'h3, "R5 rx full");
    rd(1, d); check(d, 16'h2211, "R6 first pair");
    rd(1, d); check(d, 16'h4433, "R6 second pair no 55/66");

    // overrun
    check({15'h0, overrun}, 16'h0, "R7 no overrun yet");
    send(1, 16'h8877, 2);
    send(1, 16'hAA99, 2);
    send(0, 16'h00BB, 1);
    quiet();
    check({15'h0, overrun}, 16'h1, "R7 overrun set");
    rd(1, d); check(d, 16'h8877, "R7 kept bytes");
    rd(1, d); check(d, 16'hAA99, "R7 fifth discarded");
    check({14'h0, rx_level}, 16'h0, "R7 rx empty");
    check({15'h0, overrun}, 16'h1, "R7 sticky");

    // enable cleared mid-frame
    send(1, 16'hD0C0, 2);
    wr(0, 0, 16'h0020);
    repeat (100) @(negedge clk);
    check({15'h0, busy}, 16'h0, "R11 current frame finished");
    check({14'h0, tx_level}, 16'h1, "R11 next byte held");
    check({14'h0, rx_level}, 16'h1, "R11 one frame received");
    wr(0, 0, 16'h0021);
    quiet();
    rd(1, d); check(d, 16'hD0C0, "R11 resumed");

    // divider settings
    wr(0, 0, 16'h0029);
    send(0, 16'h00E7, 1);
    quiet();
    check(16'(last_rise - prev_rise), 16'd4, "R9 divide by 4");
    wr(0, 0, 16'h0039);
    send(0, 16'h005E, 1);
    quiet();
    check(16'(last_rise - prev_rise), 16'd16, "R9 divide by 16");
    rd(1, d); check(d, 16'h5EE7, "R9 data intact");
    wr(0, 0, 16'h0000);
    check({15'h0, cs_n}, 16'h1, "R12 cs released");
    check(16'(txq.size()), 16'h0, "R1 all frames seen");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule